// File: doc/BRIEF.md
# Branch and Trap Condition Evaluator

This combinational unit sits in the execute stage of a 32-bit integer pipeline. From the opcode, the rt field and the function field of one instruction, it works out which control-transfer instruction is present. It covers compare-and-branch, branch-likely, branch-and-link, the two region jumps, and the register and immediate conditional traps. It then evaluates the condition on the two register operands, or on the register operand and the sign-extended immediate.

It returns five results. A taken flag and a trap request report the outcome of the condition. A link-write flag says that register 31 must receive the return address, and that address is given on its own output. A nullify flag tells the sequencer to cancel the delay-slot instruction of a likely branch that is not taken. The unit also gives the target address.

Exception vectoring, delay-slot sequencing and instruction fetch belong to the surrounding pipeline. The unit holds no state, so every output follows its inputs within the same cycle.

Top module: `brtrap_eval`

## Requirements
- R1: Opcode 0x04 is taken when the two register operands are equal, and opcode 0x05 is taken when they differ.
- R2: Opcode 0x06 is taken when the first operand is zero or negative (signed), and opcode 0x07 is taken when it is greater than zero. Both decode only when the rt field is 0; any other rt value leaves taken, trap, link and nullify low.
- R3: With opcode 0x01, rt 0x00 is taken when the first operand is negative and rt 0x01 is taken when it is not negative. Rt 0x10 and 0x11 test the same two conditions and also raise link. Link is raised whether or not the branch is taken.
- R4: Opcodes 0x14 to 0x17 are the likely forms of opcodes 0x04 to 0x07, with the same rt rule. With opcode 0x01, rt 0x02, 0x03, 0x12 and 0x13 are the likely forms of rt 0x00, 0x01, 0x10 and 0x11. A likely branch raises nullify exactly when it is not taken.
- R5: With opcode 0x00, function 0x30, 0x31, 0x32, 0x33, 0x34 and 0x36 raise trap when the first operand is, against the second register operand: signed greater-or-equal, unsigned greater-or-equal, signed less-than, unsigned less-than, equal, and not equal.
- R6: With opcode 0x01, rt 0x08, 0x09, 0x0A, 0x0B, 0x0C and 0x0E give the same six trap conditions as R5, in the same order. Here the first operand is compared against the sign-extended 16-bit immediate. The unsigned forms treat the sign-extended value as unsigned.
- R7: Opcodes 0x02 and 0x03 are always taken. Their target is bits 31:28 of the following-instruction address, then the 26-bit jump index, then two zero bits. Opcode 0x03 also raises link.
- R8: For every other opcode, the target is the following-instruction address plus the sign-extended immediate shifted left by two, modulo 2^32.
- R9: The link address output is always the following-instruction address plus 4, modulo 2^32.
- R10: Any opcode, rt or function value outside the sets above drives taken, trap, link and nullify low.
- R11: Taken and trap are never high together, and nullify is never high while taken is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Primary opcode field |
| rt_i | input | 5 | rt field (sub-opcode for opcode 0x01, must-be-zero for 0x06/0x07) |
| funct_i | input | 6 | Function field for opcode 0x00 |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| imm_i | input | 16 | 16-bit immediate |
| pc_next_i | input | 32 | Address of the instruction after the branch |
| jidx_i | input | 26 | 26-bit jump index |
| taken_o | output | 1 | Branch or jump taken |
| trap_o | output | 1 | Trap requested |
| link_o | output | 1 | Write link address to register 31 |
| nullify_o | output | 1 | Cancel delay-slot instruction (likely branch not taken) |
| target_o | output | 32 | Branch or jump target address |
| link_addr_o | output | 32 | Return address for linking forms |

## Verification
The unit has no register between its ports, so every result is due in the same cycle as the stimulus that produced it. The bench applies each new instruction one time unit after a rising clock edge. It compares all six outputs against its behavioural model at the following falling edge, by which time the combinational paths have settled and the next change of inputs is still half a period away. Directed cases cover the sign and unsigned corners, the nonzero-rt rule, the likely/link combinations, target wrap-around and unknown codes. A long run of biased random instructions then follows under the same timing.

// File: rtl/brtrap_pkg.sv
package brtrap_pkg;

  // primary opcodes
  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_REGIMM  = 6'h01;
  localparam logic [5:0] OP_JMP     = 6'h02;
  localparam logic [5:0] OP_JMPLNK  = 6'h03;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_BNE     = 6'h05;
  localparam logic [5:0] OP_BLEZ    = 6'h06;
  localparam logic [5:0] OP_BGTZ    = 6'h07;
  localparam logic [5:0] OP_BEQ_LK  = 6'h14;
  localparam logic [5:0] OP_BNE_LK  = 6'h15;
  localparam logic [5:0] OP_BLEZ_LK = 6'h16;
  localparam logic [5:0] OP_BGTZ_LK = 6'h17;

  // register-register trap function codes
  localparam logic [5:0] FN_TSGE = 6'h30;
  localparam logic [5:0] FN_TUGE = 6'h31;
  localparam logic [5:0] FN_TSLT = 6'h32;
  localparam logic [5:0] FN_TULT = 6'h33;
  localparam logic [5:0] FN_TEQ  = 6'h34;
  localparam logic [5:0] FN_TNE  = 6'h36;

  // condition selected by the decoder
  typedef enum logic [3:0] {
    C_NONE, C_EQ, C_NE, C_LEZ, C_GTZ, C_LTZ, C_GEZ,
    C_SGE, C_UGE, C_SLT, C_ULT, C_ALWAYS
  } cond_e;

  typedef struct packed {
    cond_e cond;
    logic  is_branch;
    logic  is_trap;
    logic  is_link;
    logic  is_likely;
    logic  is_jump;
    logic  use_imm;
  } dec_t;

endpackage

// File: rtl/brtrap_decode.sv
module brtrap_decode
  import brtrap_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [4:0] rt_i,
  input  logic [5:0] funct_i,
  output dec_t       dec_o
);

  dec_t d;

  always_comb begin
    d      = '0;
    d.cond = C_NONE;
    case (op_i)
      OP_SPECIAL: begin
        d.is_trap = 1'b1;
        case (funct_i)
          FN_TSGE: d.cond = C_SGE;
          FN_TUGE: d.cond = C_UGE;
          FN_TSLT: d.cond = C_SLT;
          FN_TULT: d.cond = C_ULT;
          FN_TEQ:  d.cond = C_EQ;
          FN_TNE:  d.cond = C_NE;
          default: d.is_trap = 1'b0;
        endcase
      end
      OP_REGIMM: begin
        case (rt_i)
          5'h00, 5'h01, 5'h02, 5'h03,
          5'h10, 5'h11, 5'h12, 5'h13: begin
            d.is_branch = 1'b1;
            d.cond      = rt_i[0] ? C_GEZ : C_LTZ;
            d.is_likely = rt_i[1];
            d.is_link   = rt_i[4];
          end
          5'h08: begin d.is_trap = 1'b1; d.use_imm = 1'b1; d.cond = C_SGE; end
          5'h09: begin d.is_trap = 1'b1; d.use_imm = 1'b1; d.cond = C_UGE; end
          5'h0A: begin d.is_trap = 1'b1; d.use_imm = 1'b1; d.cond = C_SLT; end
          5'h0B: begin d.is_trap = 1'b1; d.use_imm = 1'b1; d.cond = C_ULT; end
          5'h0C: begin d.is_trap = 1'b1; d.use_imm = 1'b1; d.cond = C_EQ;  end
          5'h0E: begin d.is_trap = 1'b1; d.use_imm = 1'b1; d.cond = C_NE;  end
          default: ;
        endcase
      end
      OP_JMP, OP_JMPLNK: begin
        d.is_jump = 1'b1;
        d.cond    = C_ALWAYS;
        d.is_link = op_i[0];
      end
      OP_BEQ, OP_BNE, OP_BEQ_LK, OP_BNE_LK: begin
        d.is_branch = 1'b1;
        d.is_likely = op_i[4];
        d.cond      = op_i[0] ? C_NE : C_EQ;
      end
      OP_BLEZ, OP_BGTZ, OP_BLEZ_LK, OP_BGTZ_LK: begin
        if (rt_i == 5'd0) begin
          d.is_branch = 1'b1;
          d.is_likely = op_i[4];
          d.cond      = op_i[0] ? C_GTZ : C_LEZ;
        end
      end
      default: ;
    endcase
  end

  assign dec_o = d;

endmodule

// File: rtl/brtrap_compare.sv
module brtrap_compare
  import brtrap_pkg::*;
#(
  parameter int W = 32
) (
  input  cond_e        cond_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         hit_o
);

  logic a_neg, a_zero;

  assign a_neg  = a_i[W-1];
  assign a_zero = (a_i == '0);

  always_comb begin
    case (cond_i)
      C_EQ:     hit_o = (a_i == b_i);
      C_NE:     hit_o = (a_i != b_i);
      C_LEZ:    hit_o = a_neg | a_zero;
      C_GTZ:    hit_o = ~a_neg & ~a_zero;
      C_LTZ:    hit_o = a_neg;
      C_GEZ:    hit_o = ~a_neg;
      C_SGE:    hit_o = ($signed(a_i) >= $signed(b_i));
      C_UGE:    hit_o = (a_i >= b_i);
      C_SLT:    hit_o = ($signed(a_i) < $signed(b_i));
      C_ULT:    hit_o = (a_i < b_i);
      C_ALWAYS: hit_o = 1'b1;
      default:  hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/brtrap_target.sv
module brtrap_target #(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [W-1:0]      pc_next_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  logic              is_jump_i,
  output logic [W-1:0]      target_o,
  output logic [W-1:0]      link_addr_o
);

  localparam int RGN_W = W - JIDX_W - 2;

  logic [W-1:0] imm_sx;
  logic [W-1:0] rel_tgt;
  logic [W-1:0] rgn_tgt;

  assign imm_sx      = {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign rel_tgt     = pc_next_i + {imm_sx[W-3:0], 2'b00};
  assign rgn_tgt     = {pc_next_i[W-1 -: RGN_W], jidx_i, 2'b00};
  assign target_o    = is_jump_i ? rgn_tgt : rel_tgt;
  assign link_addr_o = pc_next_i + W'(4);

endmodule

// File: rtl/brtrap_eval.sv
module brtrap_eval
  import brtrap_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [5:0]        op_i,
  input  logic [4:0]        rt_i,
  input  logic [5:0]        funct_i,
  input  logic [W-1:0]      rs_val_i,
  input  logic [W-1:0]      rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [W-1:0]      pc_next_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic              taken_o,
  output logic              trap_o,
  output logic              link_o,
  output logic              nullify_o,
  output logic [W-1:0]      target_o,
  output logic [W-1:0]      link_addr_o
);

  dec_t         dec;
  logic [W-1:0] cmp_b;
  logic         hit;

  brtrap_decode u_dec (
    .op_i    (op_i),
    .rt_i    (rt_i),
    .funct_i (funct_i),
    .dec_o   (dec)
  );

  assign cmp_b = dec.use_imm ? {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : rt_val_i;

  brtrap_compare #(.W(W)) u_cmp (
    .cond_i (dec.cond),
    .a_i    (rs_val_i),
    .b_i    (cmp_b),
    .hit_o  (hit)
  );

  brtrap_target #(.W(W), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc_next_i   (pc_next_i),
    .imm_i       (imm_i),
    .jidx_i      (jidx_i),
    .is_jump_i   (dec.is_jump),
    .target_o    (target_o),
    .link_addr_o (link_addr_o)
  );

  assign taken_o   = (dec.is_branch & hit) | dec.is_jump;
  assign trap_o    = dec.is_trap & hit;
  assign link_o    = dec.is_link;
  assign nullify_o = dec.is_branch & dec.is_likely & ~hit;

endmodule

// File: rtl/brtrap_eval_chk.sv
module brtrap_eval_chk #(
  parameter int W = 32
) (
  input logic [5:0]   op_i,
  input logic [4:0]   rt_i,
  input logic [W-1:0] pc_next_i,
  input logic         taken_o,
  input logic         trap_o,
  input logic         link_o,
  input logic         nullify_o,
  input logic [W-1:0] target_o
);

  logic known_op;
  logic zero_rt_op;

  always_comb begin
    known_op   = (op_i <= 6'h07) || (op_i >= 6'h14 && op_i <= 6'h17);
    zero_rt_op = (op_i == 6'h06) || (op_i == 6'h07) ||
                 (op_i == 6'h16) || (op_i == 6'h17);

    p_excl_r11: assert (!(taken_o && trap_o))
      else $error("taken and trap both high");
    p_nullify_r4: assert (!(nullify_o && taken_o))
      else $error("nullify while taken");
    p_unknown_r10: assert (known_op || (!taken_o && !trap_o && !link_o && !nullify_o))
      else $error("flags raised for unknown opcode");
    p_trap_src_r5: assert (!trap_o || op_i == 6'h00 || op_i == 6'h01)
      else $error("trap from non-trap opcode");
    p_jump_r7: assert (!(op_i == 6'h02 || op_i == 6'h03) ||
                       (taken_o && target_o[1:0] == 2'b00 &&
                        target_o[W-1 -: 4] == pc_next_i[W-1 -: 4]))
      else $error("jump target or taken wrong");
    p_rtzero_r2: assert (!(zero_rt_op && rt_i != 5'd0) ||
                         (!taken_o && !nullify_o && !link_o))
      else $error("nonzero rt decoded as branch");
  end

endmodule

bind brtrap_eval brtrap_eval_chk #(.W(W)) chk_i (
  .op_i      (op_i),
  .rt_i      (rt_i),
  .pc_next_i (pc_next_i),
  .taken_o   (taken_o),
  .trap_o    (trap_o),
  .link_o    (link_o),
  .nullify_o (nullify_o),
  .target_o  (target_o)
);

// File: tb/brtrap_eval_tb.sv
`timescale 1ns/1ps
module brtrap_eval_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [5:0]  op;
  logic [4:0]  rt;
  logic [5:0]  fn;
  logic [31:0] a, b, pcn;
  logic [15:0] imm;
  logic [25:0] ji;
  logic        taken, trap, link, nullify;
  logic [31:0] target, link_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  brtrap_eval dut_i (
    .op_i(op), .rt_i(rt), .funct_i(fn), .rs_val_i(a), .rt_val_i(b),
    .imm_i(imm), .pc_next_i(pcn), .jidx_i(ji),
    .taken_o(taken), .trap_o(trap), .link_o(link), .nullify_o(nullify),
    .target_o(target), .link_addr_o(link_addr)
  );

  // behavioural reference
  task automatic model(output bit tk, output bit tr, output bit lk, output bit nl,
                       output logic [31:0] tg, output logic [31:0] la);
    int sa, sb, si;
    logic [31:0] ui;
    bit br, likely, cond;
    sa = $signed(a); sb = $signed(b);
    si = $signed({{16{imm[15]}}, imm});
    ui = si;
    tk = 0; tr = 0; lk = 0; nl = 0; br = 0; likely = 0; cond = 0;
    tg = pcn + (ui * 4);
    la = pcn + 32'd4;
    case (op)
      6'h02, 6'h03: begin tk = 1; tg = {pcn[31:28], ji, 2'b00}; lk = (op == 6'h03); end
      6'h04, 6'h05, 6'h14, 6'h15: begin
        br = 1; likely = (op >= 6'h14); cond = (op[0]) ? (a != b) : (a == b);
      end
      6'h06, 6'h07, 6'h16, 6'h17: if (rt == 0) begin
        br = 1; likely = (op >= 6'h14); cond = (op[0]) ? (sa > 0) : (sa <= 0);
      end
      6'h01: begin
        if (rt inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h10, 5'h11, 5'h12, 5'h13}) begin
          br = 1; cond = rt[0] ? (sa >= 0) : (sa < 0);
          likely = rt[1]; lk = rt[4];
        end else case (rt)
          5'h08: tr = (sa >= si);
          5'h09: tr = (a >= ui);
          5'h0A: tr = (sa < si);
          5'h0B: tr = (a < ui);
          5'h0C: tr = (a == ui);
          5'h0E: tr = (a != ui);
          default: ;
        endcase
      end
      6'h00: case (fn)
        6'h30: tr = (sa >= sb);
        6'h31: tr = (a >= b);
        6'h32: tr = (sa < sb);
        6'h33: tr = (a < b);
        6'h34: tr = (a == b);
        6'h36: tr = (a != b);
        default: ;
      endcase
      default: ;
    endcase
    if (br) begin tk = cond; nl = likely && !cond; end
  endtask

  task automatic cmp1(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, nm, act, exp);
    end
  endtask

  task automatic check_now(string tag);
    bit tk, tr, lk, nl;
    logic [31:0] tg, la;
    model(tk, tr, lk, nl, tg, la);
    cmp1(tag, "taken", {31'd0, taken}, {31'd0, tk});
    cmp1(tag, "trap", {31'd0, trap}, {31'd0, tr});
    cmp1(tag, "link", {31'd0, link}, {31'd0, lk});
    cmp1(tag, "nullify", {31'd0, nullify}, {31'd0, nl});
    cmp1((op == 6'h02 || op == 6'h03) ? "R7" : "R8", "target", target, tg);
    cmp1("R9", "link_addr", link_addr, la);
    cmp1("R11", "excl", {31'd0, taken & (trap | nullify)}, 32'd0);
  endtask

  task automatic apply(string tag, logic [5:0] o, logic [4:0] r, logic [5:0] f,
                       logic [31:0] va, logic [31:0] vb, logic [15:0] im,
                       logic [31:0] pc, logic [25:0] j);
    @(posedge clk);
    #1;
    op = o; rt = r; fn = f; a = va; b = vb; imm = im; pcn = pc; ji = j;
    @(negedge clk);
    check_now(tag);
  endtask

  function automatic string tag_of(logic [5:0] o, logic [4:0] r);
    if (o == 6'h04 || o == 6'h05) return "R1";
    if (o == 6'h06 || o == 6'h07) return "R2";
    if (o >= 6'h14 && o <= 6'h17) return "R4";
    if (o == 6'h02 || o == 6'h03) return "R7";
    if (o == 6'h00) return "R5";
    if (o == 6'h01) return r[3] ? "R6" : "R3";
    return "R10";
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return $urandom % 8;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    op = 0; rt = 0; fn = 0; a = 0; b = 0; imm = 0; pcn = 0; ji = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("R10 reset state");
    rst_n = 1'b1;

    apply("R1 beq equal",      6'h04, 0, 0, 32'h1234, 32'h1234, 16'h0010, 32'h400, 0);
    apply("R1 beq differ",     6'h04, 0, 0, 32'h1234, 32'h1235, 16'h0010, 32'h400, 0);
    apply("R1 bne equal",      6'h05, 0, 0, 32'h5, 32'h5, 16'h0002, 32'h400, 0);
    apply("R2 blez zero",      6'h06, 0, 0, 32'h0, 0, 16'h0003, 32'h800, 0);
    apply("R2 bgtz zero",      6'h07, 0, 0, 32'h0, 0, 16'h0003, 32'h800, 0);
    apply("R2 bgtz min",       6'h07, 0, 0, 32'h8000_0000, 0, 16'h0003, 32'h800, 0);
    apply("R2 blez rt nonzero",6'h06, 5'h01, 0, 32'h0, 0, 16'h0003, 32'h800, 0);
    apply("R3 bltzal positive",6'h01, 5'h10, 0, 32'h1, 0, 16'h0004, 32'h900, 0);
    apply("R3 bgez negative",  6'h01, 5'h01, 0, 32'hFFFF_FFFF, 0, 16'h0004, 32'h900, 0);
    apply("R4 bgezl not taken",6'h01, 5'h03, 0, 32'hFFFF_FFFF, 0, 16'h0004, 32'h900, 0);
    apply("R4 bltzall taken",  6'h01, 5'h12, 0, 32'h8000_0000, 0, 16'h0004, 32'h900, 0);
    apply("R4 beql taken",     6'h14, 0, 0, 32'h7, 32'h7, 16'h0001, 32'h900, 0);
    apply("R4 bnel not taken", 6'h15, 0, 0, 32'h7, 32'h7, 16'h0001, 32'h900, 0);
    apply("R4 blezl rt nonzero",6'h16, 5'h04, 0, 32'h0, 0, 16'h0001, 32'h900, 0);
    apply("R5 tge signed",     6'h00, 0, 6'h30, 32'hFFFF_FFFF, 32'h1, 0, 32'h100, 0);
    apply("R5 tgeu unsigned",  6'h00, 0, 6'h31, 32'hFFFF_FFFF, 32'h1, 0, 32'h100, 0);
    apply("R5 tltu",           6'h00, 0, 6'h33, 32'h1, 32'hFFFF_FFFF, 0, 32'h100, 0);
    apply("R5 tne equal",      6'h00, 0, 6'h36, 32'h9, 32'h9, 0, 32'h100, 0);
    apply("R6 tltiu sext",     6'h01, 5'h0B, 0, 32'h5, 0, 16'hFFFF, 32'h100, 0);
    apply("R6 tgei minus one", 6'h01, 5'h08, 0, 32'h0, 0, 16'hFFFF, 32'h100, 0);
    apply("R6 teqi sext",      6'h01, 5'h0C, 0, 32'hFFFF_8000, 0, 16'h8000, 32'h100, 0);
    apply("R7 j region",       6'h02, 0, 0, 0, 0, 16'h1234, 32'hA000_0010, 26'h3FF_FFFF);
    apply("R7 jal link",       6'h03, 0, 0, 0, 0, 16'h1234, 32'h5000_0000, 26'h000_0001);
    apply("R8 negative offset",6'h04, 0, 0, 0, 0, 16'hFFFF, 32'h0000_0100, 0);
    apply("R9 link wrap",      6'h01, 5'h11, 0, 0, 0, 16'h0000, 32'hFFFF_FFFC, 0);
    apply("R10 unknown op",    6'h08, 0, 0, 0, 0, 0, 32'h100, 0);
    apply("R10 unknown funct", 6'h00, 0, 6'h35, 32'h3, 32'h3, 0, 32'h100, 0);
    apply("R10 unknown regimm",6'h01, 5'h0D, 0, 32'h3, 0, 16'h0003, 32'h100, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [5:0] ro;
      logic [4:0] rr;
      logic [31:0] va;
      case ($urandom % 16)
        0: ro = 6'h00; 1: ro = 6'h01; 2: ro = 6'h01; 3: ro = 6'h02;
        4: ro = 6'h03; 5: ro = 6'h04; 6: ro = 6'h05; 7: ro = 6'h06;
        8: ro = 6'h07; 9: ro = 6'h14; 10: ro = 6'h15; 11: ro = 6'h16;
        12: ro = 6'h17; 13: ro = 6'h00; default: ro = 6'($urandom);
      endcase
      rr = ($urandom % 4 == 0) ? 5'($urandom) : ((ro == 6'h01) ? 5'($urandom % 20) : 5'd0);
      va = pick();
      apply(tag_of(ro, rr), ro, rr, 6'h30 + 6'($urandom % 8), va,
            ($urandom % 3 == 0) ? va : pick(), 16'($urandom), $urandom, 26'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule